// File: doc/BRIEF.md
# Sequential Next-Block Stream Prefetcher

This unit sits beside an instruction cache and handles its misses. The cache reports each miss as a block address on a valid/ready channel. The unit keeps one stream-buffer entry. That entry holds a block address, the block data, a valid bit and a bit that marks a memory response as still outstanding. When a miss also misses the entry, the unit fetches the demanded block and sends it to the cache's fill port. It then prefetches the next sequential block into the entry. When a miss hits the entry, the buffered block is promoted straight to the fill port and the block after it is prefetched. A run of sequential misses therefore costs one memory round trip per block, and from the second block on that round trip overlaps the cache's own work.

The unit has three interfaces. Memory requests go out on a valid/ready channel, one at a time, and the demand fetch always goes before the prefetch. Memory responses come back in request order as a plain valid strobe with data; the unit always accepts them. Fills go to the cache on a valid/ready channel, and a flag on that channel tells whether the block came from the stream buffer.

Back-pressure rules:
- A request or fill that has been raised keeps its valid high and its payload unchanged until ready is seen.
- A new miss is accepted only when the unit is idle, so the cache's miss channel stalls for the whole time a miss is being served.

Top module: `seq_stream_prefetcher`

## Requirements
- R1: After reset, miss_ready is 1, and mem_req_valid and fill_valid are both 0.
- R2: A miss to block A that does not hit the stream buffer issues exactly two memory requests, in this order: address A, then A+1. Only one request is offered at a time, and the A+1 request is raised in the cycle after the fill handshake.
- R3: On a demand fetch, the fill channel carries fill_addr = A, the data of the first memory response after the demand request, and fill_from_buf = 0.
- R4: A miss to A that hits a stream-buffer entry whose data has already arrived issues no demand request. It fills A with the buffered data and fill_from_buf = 1, and then issues a single request for A+1.
- R5: A miss that hits the stream-buffer entry while that entry's prefetch response is still outstanding waits for the response. It then fills with that response's data and fill_from_buf = 1, and issues no demand request.
- R6: A miss that misses the stream buffer while an unrelated prefetch is outstanding first absorbs and discards that response. It then issues the demand request, and the stale data never reaches the fill port.
- R7: Under back-pressure, mem_req_valid and fill_valid stay high, and mem_req_addr and fill_addr stay stable, until the matching ready is seen.
- R8: Each accepted miss produces exactly one fill, and miss_ready is 0 in the cycle after a miss is accepted.
- R9: Block addresses wrap: a miss on the highest block address prefetches block 0, and a later miss on block 0 hits the stream buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Cache presents a missing block |
| miss_ready | output | 1 | Unit idle and accepting a miss |
| miss_addr | input | ADDR_W | Block address of the miss |
| mem_req_valid | output | 1 | Memory read request offered |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Block address requested |
| mem_rsp_valid | input | 1 | In-order memory response strobe |
| mem_rsp_data | input | DATA_W | Response block data |
| fill_valid | output | 1 | Block offered to the cache |
| fill_ready | input | 1 | Cache accepts the fill |
| fill_addr | output | ADDR_W | Block address of the fill |
| fill_data | output | DATA_W | Block data of the fill |
| fill_from_buf | output | 1 | 1 when the fill came from the stream buffer |

## Verification
The assertions check properties that hold on every cycle. Requests and fills must hold under back-pressure. A prefetch may be allocated only when no response is outstanding, so at most one request is in flight at a time. A request must follow every fill, and the miss channel must close once a miss is accepted. The bench scenarios cover what depends on which blocks are chosen and which data goes with them. These are the request order for cold misses, promotion from a ready entry or a pending entry, and discarding a stale prefetch. They also cover address wraparound and the one-fill-per-miss count under irregular ready patterns.

// File: rtl/spf_pkg.sv
package spf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DRAIN = 3'd1,
    ST_DREQ  = 3'd2,
    ST_DWAIT = 3'd3,
    ST_BWAIT = 3'd4,
    ST_FILL  = 3'd5,
    ST_PREQ  = 3'd6
  } spf_state_e;
endpackage

// File: rtl/spf_entry.sv
module spf_entry #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] look_addr,
  input  logic              clr,
  input  logic              alloc,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              hit,
  output logic              pend,
  output logic [DATA_W-1:0] data
);
  logic              valid_q;
  logic              pend_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pend_q  <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      if (alloc) begin
        valid_q <= 1'b1;
        pend_q  <= 1'b1;
        addr_q  <= alloc_addr;
      end else begin
        if (clr) valid_q <= 1'b0;
        if (rsp_valid && pend_q) begin
          pend_q <= 1'b0;
          data_q <= rsp_data;
        end
      end
    end
  end

  assign hit  = valid_q && (addr_q == look_addr);
  assign pend = pend_q;
  assign data = data_q;

  AST_ALLOC_NO_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !pend_q); // R2
endmodule

// File: rtl/spf_ctrl.sv
module spf_ctrl
  import spf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic              buf_hit,
  input  logic              buf_pend,
  input  logic [DATA_W-1:0] buf_data,
  output logic              buf_clr,
  output logic              buf_alloc,
  output logic [ADDR_W-1:0] buf_alloc_addr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              fill_valid,
  input  logic              fill_ready,
  output logic [ADDR_W-1:0] fill_addr,
  output logic [DATA_W-1:0] fill_data,
  output logic              fill_from_buf
);
  spf_state_e        st_q;
  logic [ADDR_W-1:0] cur_q;
  logic [DATA_W-1:0] fdata_q;
  logic              fsrc_q;
  logic              miss_fire;
  logic [ADDR_W-1:0] next_addr;

  assign miss_ready = (st_q == ST_IDLE);
  assign miss_fire  = miss_valid && miss_ready;
  assign next_addr  = cur_q + ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cur_q   <= '0;
      fdata_q <= '0;
      fsrc_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (miss_fire) begin
          cur_q <= miss_addr;
          if (buf_hit) begin
            fsrc_q <= 1'b1;
            if (!buf_pend) begin
              fdata_q <= buf_data;
              st_q    <= ST_FILL;
            end else if (rsp_valid) begin
              fdata_q <= rsp_data;
              st_q    <= ST_FILL;
            end else begin
              st_q <= ST_BWAIT;
            end
          end else begin
            fsrc_q <= 1'b0;
            st_q   <= (buf_pend && !rsp_valid) ? ST_DRAIN : ST_DREQ;
          end
        end
        ST_DRAIN: if (rsp_valid) st_q <= ST_DREQ;
        ST_DREQ:  if (mem_req_ready) st_q <= ST_DWAIT;
        ST_DWAIT: if (rsp_valid) begin
          fdata_q <= rsp_data;
          st_q    <= ST_FILL;
        end
        ST_BWAIT: if (rsp_valid) begin
          fdata_q <= rsp_data;
          st_q    <= ST_FILL;
        end
        ST_FILL:  if (fill_ready) st_q <= ST_PREQ;
        ST_PREQ:  if (mem_req_ready) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign buf_clr        = miss_fire && !buf_hit;
  assign mem_req_valid  = (st_q == ST_DREQ) || (st_q == ST_PREQ);
  assign mem_req_addr   = (st_q == ST_PREQ) ? next_addr : cur_q;
  assign buf_alloc      = (st_q == ST_PREQ) && mem_req_ready;
  assign buf_alloc_addr = next_addr;
  assign fill_valid     = (st_q == ST_FILL);
  assign fill_addr      = cur_q;
  assign fill_data      = fdata_q;
  assign fill_from_buf  = fsrc_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R7
  AST_FILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !fill_ready) |=> (fill_valid && $stable(fill_addr) && $stable(fill_data))); // R7
  AST_PREFETCH_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready) |=> mem_req_valid); // R2
  AST_MISS_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    miss_fire |=> !miss_ready); // R8
endmodule

// File: rtl/seq_stream_prefetcher.sv
module seq_stream_prefetcher #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              fill_valid,
  input  logic              fill_ready,
  output logic [ADDR_W-1:0] fill_addr,
  output logic [DATA_W-1:0] fill_data,
  output logic              fill_from_buf
);
  logic              buf_hit, buf_pend, buf_clr, buf_alloc;
  logic [DATA_W-1:0] buf_data;
  logic [ADDR_W-1:0] buf_alloc_addr;

  spf_entry #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_entry (
    .clk        (clk),
    .rst_n      (rst_n),
    .look_addr  (miss_addr),
    .clr        (buf_clr),
    .alloc      (buf_alloc),
    .alloc_addr (buf_alloc_addr),
    .rsp_valid  (mem_rsp_valid),
    .rsp_data   (mem_rsp_data),
    .hit        (buf_hit),
    .pend       (buf_pend),
    .data       (buf_data)
  );

  spf_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .miss_valid     (miss_valid),
    .miss_ready     (miss_ready),
    .miss_addr      (miss_addr),
    .buf_hit        (buf_hit),
    .buf_pend       (buf_pend),
    .buf_data       (buf_data),
    .buf_clr        (buf_clr),
    .buf_alloc      (buf_alloc),
    .buf_alloc_addr (buf_alloc_addr),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_req_addr   (mem_req_addr),
    .rsp_valid      (mem_rsp_valid),
    .rsp_data       (mem_rsp_data),
    .fill_valid     (fill_valid),
    .fill_ready     (fill_ready),
    .fill_addr      (fill_addr),
    .fill_data      (fill_data),
    .fill_from_buf  (fill_from_buf)
  );

  AST_FILL_SRC_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready && buf_hit) |=> !mem_req_valid); // R4
endmodule

// File: tb/seq_stream_prefetcher_test.sv
module seq_stream_prefetcher_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int LAT = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          miss_valid = 1'b0;
  logic          miss_ready;
  logic [AW-1:0] miss_addr = '0;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b1;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic          fill_valid;
  logic          fill_ready = 1'b1;
  logic [AW-1:0] fill_addr;
  logic [DW-1:0] fill_data;
  logic          fill_from_buf;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit bp_on = 1'b0;
  bit done = 1'b0;

  logic [AW-1:0] exp_req_q [$];
  logic [AW+DW:0] exp_fill_q [$];
  logic [AW-1:0] mem_addr_q [$];
  int            mem_due_q [$];

  bit            m_valid = 1'b0;
  logic [AW-1:0] m_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seq_stream_prefetcher #(.ADDR_W(AW), .DATA_W(DW)) uut (.*);

  function automatic logic [DW-1:0] mem_word(logic [AW-1:0] a);
    return {a ^ 16'h5A5A, a};
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // memory model and request monitor
  initial begin
    forever begin
      @(negedge clk);
      mem_req_ready = bp_on ? (cyc % 3 != 0) : 1'b1;
      mem_rsp_valid = 1'b0;
      if (mem_addr_q.size() > 0 && mem_due_q[0] <= cyc) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_word(mem_addr_q[0]);
        void'(mem_addr_q.pop_front());
        void'(mem_due_q.pop_front());
      end
      if (mem_req_valid && mem_req_ready) begin
        if (exp_req_q.size() == 0) begin
          check(1'b0, "R2 unexpected request", 64'(mem_req_addr), 64'hFFFF_FFFF);
        end else begin
          // R2 R6 R9: requested block order
          check(mem_req_addr == exp_req_q[0], "R2 request addr", 64'(mem_req_addr), 64'(exp_req_q[0]));
          void'(exp_req_q.pop_front());
        end
        mem_addr_q.push_back(mem_req_addr);
        mem_due_q.push_back(cyc + 1 + LAT);
      end
    end
  end

  // fill monitor
  initial begin
    bit            held = 1'b0;
    logic [AW-1:0] held_addr = '0;
    forever begin
      @(negedge clk);
      if (held) begin
        check(fill_valid && fill_addr == held_addr, "R7 fill hold", 64'(fill_addr), 64'(held_addr));
      end
      fill_ready = bp_on ? (cyc % 4 < 2) : 1'b1;
      held = fill_valid && !fill_ready;
      held_addr = fill_addr;
      if (fill_valid && fill_ready) begin
        if (exp_fill_q.size() == 0) begin
          check(1'b0, "R8 extra fill", 64'(fill_addr), 64'hFFFF_FFFF);
        end else begin
          // R3 R4 R5: fill addr, data and source flag
          check({fill_from_buf, fill_addr, fill_data} == exp_fill_q[0], "R3/R4/R5 fill",
                64'({fill_from_buf, fill_addr, fill_data}), 64'(exp_fill_q[0]));
          void'(exp_fill_q.pop_front());
        end
      end
    end
  end

  task automatic do_miss(logic [AW-1:0] a);
    bit hit;
    while (!miss_ready) @(negedge clk);
    hit = m_valid && (m_addr == a);
    if (!hit) exp_req_q.push_back(a);
    exp_req_q.push_back(a + AW'(1));
    exp_fill_q.push_back({hit, a, mem_word(a)});
    m_valid = 1'b1;
    m_addr  = a + AW'(1);
    miss_valid = 1'b1;
    miss_addr  = a;
    @(negedge clk);
    miss_valid = 1'b0;
    check(!miss_ready, "R8 miss_ready low after accept", 64'(miss_ready), 64'd0);
  endtask

  task automatic settle();
    while (!(miss_ready && exp_req_q.size() == 0 && exp_fill_q.size() == 0 &&
             mem_addr_q.size() == 0)) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(miss_ready == 1'b1, "R1 miss_ready", 64'(miss_ready), 64'd1);
    check(mem_req_valid == 1'b0, "R1 mem_req_valid", 64'(mem_req_valid), 64'd0);
    check(fill_valid == 1'b0, "R1 fill_valid", 64'(fill_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    do_miss(16'h0010);          // R2 R3 cold miss
    settle();
    do_miss(16'h0011);          // R4 ready entry
    settle();
    do_miss(16'h0012);          // R4 then R5 back to back
    do_miss(16'h0013);          // R5 pending entry
    do_miss(16'h0080);          // R6 stale prefetch outstanding
    settle();
    bp_on = 1'b1;               // R7 back-pressure on both channels
    do_miss(16'h0081);
    do_miss(16'h0082);
    do_miss(16'h0200);
    do_miss(16'h0201);
    settle();
    bp_on = 1'b0;
    do_miss(16'hFFFF);          // R9 wrap
    settle();
    do_miss(16'h0000);          // R9 hit on wrapped block
    do_miss(16'h0005);          // R6 again
    settle();
    check(exp_fill_q.size() == 0, "R8 all fills seen", 64'(exp_fill_q.size()), 64'd0);
    check(exp_req_q.size() == 0, "R2 all requests seen", 64'(exp_req_q.size()), 64'd0);
    done = 1'b1;
  end

  initial begin
    int n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", n);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule